// File: doc/BRIEF.md
# Framed Register-File Access Slave

This block holds eight byte-wide registers and serves read and write requests that arrive as framed byte streams. The request channel and the response channel both use a valid/accept handshake and carry a start marker on the first beat of a frame and a stop marker on the last beat. The first byte of every request is a header: the register address sits in bits [7:4] and the command code in bits [3:0].

A read request is one beat. The slave answers with three beats: the echoed header, the register value, and a footer. A write request is two beats: the header, then the data byte. The slave answers with two beats: the echoed header and a footer. The footer byte is 0 when the address is in range and 1 when it is not. A write whose data beat lacks the stop marker is dropped without any response.

The response channel follows backpressure. A beat that is waiting for acceptance keeps all of its fields unchanged. Between accepted beats there is always one idle cycle.

Top module: `regframe_slave`

## Requirements
- R1: A synchronous active-low reset clears every register to 0 and leaves `out_valid` and `in_accept` low while it is held. One cycle after release, the slave waits for a header with `in_accept` high.
- R2: `in_accept` is high only while the slave waits for a header or for write data. It is low while a response is being produced.
- R3: A read request is a single beat with start and stop both set and command 4'h0. The response is three beats. Beat 1 is the header byte with start only. Beat 2 is the addressed register value with no marker. Beat 3 is the footer with stop only.
- R4: A write request is a header with start set, stop clear and command 4'h1, followed by a data beat with stop set. An in-range address stores the data byte. The response is two beats: the header with start, then a footer with value 0 and stop.
- R5: A read to address 8 to 15 returns data byte 0 and footer value 1, and changes no register.
- R6: A write to address 8 to 15 changes no register and returns footer value 1. Address 7 is the last address that is written.
- R7: A write data beat without the stop marker drops the request. There is no response, no register changes, and the slave waits for a new header.
- R8: In the header wait, the slave consumes and ignores the following beats, produces no response and stays in the header wait: a beat without start, a beat with an unknown command, a read header without stop, and a write header with stop.
- R9: After each accepted response beat, `out_valid` is low for exactly one cycle before the next beat of the same frame.
- R10: While `out_valid` is high and `out_accept` is low, `out_valid`, `out_byte`, `out_start` and `out_stop` keep their values.
- R11: `out_start` and `out_stop` are never high together.
- R12: A read never changes register contents. Repeated reads of the same address return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request beat present |
| in_accept | output | 1 | Slave takes the request beat this cycle |
| in_start | input | 1 | First beat of a request frame |
| in_stop | input | 1 | Last beat of a request frame |
| in_byte | input | 8 | Request byte |
| out_valid | output | 1 | Response beat present |
| out_accept | input | 1 | Receiver takes the response beat |
| out_start | output | 1 | First beat of a response frame |
| out_stop | output | 1 | Last beat of a response frame |
| out_byte | output | 8 | Response byte |

## Verification
Two decisions fall in the same cycle of the write-data state: the address range check and the register write enable. Both also set the footer error bit. The bench provokes this with writes to address 7, the last valid address, and then to addresses 8 and 15. It judges the result from the footer byte of each response and from a full read-back of all eight registers against its own model. Response beats are also stalled for a varying number of cycles, so that the hold rule and the one-cycle gap are exercised on every kind of beat.

// File: rtl/regframe_pkg.sv
package regframe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_RDREG = 3'd2,
    ST_WRDAT = 3'd3,
    ST_OHDR  = 3'd4,
    ST_ODAT  = 3'd5,
    ST_OFTR  = 3'd6
  } state_t;

  // address inside the implemented register file
  function automatic logic addr_in_range(input logic [3:0] a, input int unsigned nreg);
    return 32'(a) < nreg;
  endfunction

endpackage

// File: rtl/regframe_regs.sv
module regframe_regs #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] rd_vec [NREG];
  logic          rd_ok;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                              q <= '0;
        else if (wr_en && wr_addr == AW'(i))     q <= wr_data;
      end
      assign rd_vec[i] = q;
    end
  endgenerate

  assign rd_ok   = 32'(rd_addr) < NREG;
  assign rd_data = rd_ok ? rd_vec[rd_addr[IDXW-1:0]] : '0;

  // R6
  write_in_range_chk : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < NREG));

endmodule

// File: rtl/regframe_ctrl.sv
module regframe_ctrl
  import regframe_pkg::*;
#(
  parameter int            NREG   = 8,
  parameter int            DW     = 8,
  parameter int            AW     = 4,
  parameter int            CW     = 4,
  parameter logic [CW-1:0] CMD_RD = 4'h0,
  parameter logic [CW-1:0] CMD_WR = 4'h1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_accept,
  input  logic          in_start,
  input  logic          in_stop,
  input  logic [DW-1:0] in_byte,
  output logic          out_valid,
  input  logic          out_accept,
  output logic          out_start,
  output logic          out_stop,
  output logic [DW-1:0] out_byte,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  state_t        state_q, state_d;
  logic [DW-1:0] hdr_q;
  logic [DW-1:0] rdata_q;
  logic          err_q;
  logic          gap_q;

  logic [CW-1:0] in_cmd;
  logic          is_rd_req, is_wr_req;
  logic [AW-1:0] cur_addr;
  logic          addr_ok;
  logic          beat_done;
  logic          in_out_phase;

  assign in_cmd    = in_byte[CW-1:0];
  assign is_rd_req = in_valid && in_start && in_stop  && in_cmd == CMD_RD;
  assign is_wr_req = in_valid && in_start && !in_stop && in_cmd == CMD_WR;
  assign cur_addr  = hdr_q[CW +: AW];
  assign addr_ok   = addr_in_range(4'(cur_addr), NREG);

  assign in_accept    = (state_q == ST_HDR) || (state_q == ST_WRDAT);
  assign in_out_phase = (state_q == ST_OHDR) || (state_q == ST_ODAT) || (state_q == ST_OFTR);
  assign out_valid    = in_out_phase && !gap_q;
  assign out_start    = out_valid && state_q == ST_OHDR;
  assign out_stop     = out_valid && state_q == ST_OFTR;
  assign beat_done    = out_valid && out_accept;

  always_comb begin
    case (state_q)
      ST_OHDR: out_byte = hdr_q;
      ST_ODAT: out_byte = rdata_q;
      ST_OFTR: out_byte = DW'(err_q);
      default: out_byte = '0;
    endcase
  end

  assign wr_en   = state_q == ST_WRDAT && in_valid && in_stop && addr_ok;
  assign wr_addr = cur_addr;
  assign wr_data = in_byte;
  assign rd_addr = cur_addr;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  state_d = ST_HDR;
      ST_HDR:   if (is_rd_req) state_d = ST_RDREG;
                else if (is_wr_req) state_d = ST_WRDAT;
      ST_RDREG: state_d = ST_OHDR;
      ST_WRDAT: if (in_valid) state_d = in_stop ? ST_OHDR : ST_IDLE;
      ST_OHDR:  if (beat_done) state_d = (hdr_q[CW-1:0] == CMD_RD) ? ST_ODAT : ST_OFTR;
      ST_ODAT:  if (beat_done) state_d = ST_OFTR;
      ST_OFTR:  if (beat_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      gap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      gap_q   <= beat_done;
      case (state_q)
        ST_HDR: begin
          err_q <= 1'b0;
          if (is_rd_req || is_wr_req) hdr_q <= in_byte;
        end
        ST_RDREG: begin
          err_q   <= !addr_ok;
          rdata_q <= addr_ok ? rd_data : '0;
        end
        ST_WRDAT: if (in_valid && in_stop) err_q <= !addr_ok;
        default: ;
      endcase
    end
  end

  // R3
  header_held_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_RDREG, ST_WRDAT, ST_OHDR, ST_ODAT, ST_OFTR}) |=> $stable(hdr_q));

  // R5
  bad_read_zero_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start && !out_stop && err_q) |-> out_byte == '0);

  // R9
  gap_after_beat_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_accept) |=> !out_valid);

  // R10
  hold_under_stall_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_accept) |=>
      ($stable(out_valid) && $stable(out_byte) && $stable(out_start) && $stable(out_stop)));

  // R11
  markers_exclusive_chk : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_start, out_stop}));

  // R2
  no_accept_in_reply_chk : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_accept);

endmodule

// File: rtl/regframe_slave.sv
module regframe_slave #(
  parameter int         NREG   = 8,
  parameter int         DW     = 8,
  parameter int         AW     = 4,
  parameter int         CW     = 4,
  parameter logic [3:0] CMD_RD = 4'h0,
  parameter logic [3:0] CMD_WR = 4'h1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_accept,
  input  logic          in_start,
  input  logic          in_stop,
  input  logic [DW-1:0] in_byte,
  output logic          out_valid,
  input  logic          out_accept,
  output logic          out_start,
  output logic          out_stop,
  output logic [DW-1:0] out_byte
);
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  regframe_ctrl #(
    .NREG(NREG), .DW(DW), .AW(AW), .CW(CW),
    .CMD_RD(CW'(CMD_RD)), .CMD_WR(CW'(CMD_WR))
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_accept(in_accept), .in_start(in_start),
    .in_stop(in_stop), .in_byte(in_byte),
    .out_valid(out_valid), .out_accept(out_accept), .out_start(out_start),
    .out_stop(out_stop), .out_byte(out_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  regframe_regs #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

endmodule

// File: tb/regframe_slave_tb_top.sv
module regframe_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_start = 1'b0, in_stop = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_accept;
  logic       out_valid, out_start, out_stop;
  logic       out_accept = 1'b0;
  logic [7:0] out_byte;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [8];

  always #10 clk = ~clk;

  regframe_slave dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_accept(in_accept), .in_start(in_start),
    .in_stop(in_stop), .in_byte(in_byte),
    .out_valid(out_valid), .out_accept(out_accept), .out_start(out_start),
    .out_stop(out_stop), .out_byte(out_byte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bench view of the address rule
  function automatic bit valid_addr(input int a);
    return a >= 0 && a <= 7;
  endfunction

  task automatic put_beat(input bit s, input bit p, input logic [7:0] b);
    @(negedge clk);
    while (!in_accept) @(negedge clk);
    in_valid = 1'b1; in_start = s; in_stop = p; in_byte = b;
    @(posedge clk); #1;
    in_valid = 1'b0; in_start = 1'b0; in_stop = 1'b0;
  endtask

  task automatic get_beat(input bit es, input bit ep, input logic [7:0] eb,
                          input int stall, input bit first, input string tag);
    int waits = 0;
    @(negedge clk);
    while (!out_valid) begin waits++; @(negedge clk); end
    if (!first) check(waits == 0, {tag, " R9 single gap"}, waits, 0);
    check(out_start == es, {tag, " R3 start marker"}, out_start, es);
    check(out_stop == ep, {tag, " R3 stop marker"}, out_stop, ep);
    check(!(out_start && out_stop), {tag, " R11 markers"}, {out_start, out_stop}, 0);
    check(out_byte == eb, {tag, " byte"}, out_byte, eb);
    check(!in_accept, {tag, " R2 no accept"}, in_accept, 0);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(out_valid && out_start == es && out_stop == ep && out_byte == eb,
            {tag, " R10 hold"}, {out_valid, out_start, out_stop, out_byte}, {1'b1, es, ep, eb});
    end
    out_accept = 1'b1;
    @(posedge clk); #1;
    out_accept = 1'b0;
    @(negedge clk);
    check(!out_valid, {tag, " R9 gap"}, out_valid, 0);
  endtask

  task automatic do_write(input int a, input logic [7:0] d, input int stall, input string tag);
    logic [7:0] h = {4'(a), 4'h1};
    bit bad = !valid_addr(a);
    put_beat(1'b1, 1'b0, h);
    put_beat(1'b0, 1'b1, d);
    get_beat(1'b1, 1'b0, h, stall, 1'b1, {tag, " R4 hdr"});
    get_beat(1'b0, 1'b1, {7'd0, bad}, stall, 1'b0, {tag, " R4 R6 footer"});
    if (!bad) model[a] = d;
  endtask

  task automatic do_read(input int a, input int stall, input string tag);
    logic [7:0] h = {4'(a), 4'h0};
    bit bad = !valid_addr(a);
    logic [7:0] exp_d = bad ? 8'h00 : model[a];
    put_beat(1'b1, 1'b1, h);
    get_beat(1'b1, 1'b0, h, stall, 1'b1, {tag, " R3 hdr"});
    get_beat(1'b0, 1'b0, exp_d, stall, 1'b0, {tag, " R3 R5 data"});
    get_beat(1'b0, 1'b1, {7'd0, bad}, stall, 1'b0, {tag, " R5 footer"});
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 8; a++) do_read(a, a % 3, tag);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(!out_valid, {tag, " no response"}, out_valid, 0);
    end
    check(in_accept, {tag, " R2 header wait"}, in_accept, 1);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) model[a] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 valid in reset", out_valid, 0);
    check(!in_accept, "R1 accept in reset", in_accept, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(in_accept, "R1 header wait after reset", in_accept, 1);
    read_all("R1 reset value");
  endtask

  task automatic t_writes();
    for (int a = 0; a < 8; a++) do_write(a, 8'(a * 37 + 5), (a + 1) % 3, "R4 write");
    read_all("R4 readback");
    read_all("R12 second read");
  endtask

  task automatic t_boundary();
    do_write(7, 8'hA7, 2, "R6 last addr");
    do_write(8, 8'h5A, 1, "R6 addr8");
    do_write(15, 8'hC3, 0, "R6 addr15");
    read_all("R6 unchanged");
    do_read(9, 2, "R5 bad read");
    do_read(15, 0, "R5 bad read top");
    read_all("R5 unchanged");
  endtask

  task automatic t_drop();
    put_beat(1'b1, 1'b0, {4'd2, 4'h1});
    put_beat(1'b0, 1'b0, 8'hEE);
    quiet(6, "R7 drop");
    do_read(2, 1, "R7 reg kept");
  endtask

  task automatic t_ignored();
    put_beat(1'b0, 1'b1, {4'd3, 4'h0});
    quiet(4, "R8 no start");
    put_beat(1'b1, 1'b1, {4'd3, 4'h5});
    quiet(4, "R8 bad cmd");
    put_beat(1'b1, 1'b0, {4'd3, 4'h0});
    quiet(4, "R8 read no stop");
    put_beat(1'b1, 1'b1, {4'd3, 4'h1});
    quiet(4, "R8 write with stop");
    do_read(3, 0, "R8 after ignored");
    read_all("R8 unchanged");
  endtask

  initial begin
    t_reset();
    t_writes();
    t_boundary();
    t_drop();
    t_ignored();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule